// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block turns a memory page number (4 KiB pages) into the chip-select row that holds it. Software first loads eight cumulative boundary values, one byte per row, where each value is the top of memory through that row in units of 32 MiB or 64 MiB. It also loads an attribute word that gives each row's device width, and a controller mode word that gives the boundary unit, the channel mode and the ECC enable. From these the block reports, per row, whether the row holds memory, whether it uses x4 devices, and which error-correction scheme applies.

Lookups are a stream. A page number enters on a valid/ready request port. One cycle later a registered response gives the row index and a miss flag. The response is held until the consumer takes it. A new request is accepted only when the output register is empty or being drained in the same cycle, so back-pressure on the response side stalls the request side at once. A strap input marks device variants that always run dual-channel. On those variants the boundary unit is fixed at 64 MiB.

Top module: `row_map_decoder`

## Requirements
- R1: After reset all boundary, width and mode storage is zero. No row reports populated, every row reports ECC code 0, `rsp_valid` is low and `req_ready` is high.
- R2: A write with `cfg_we` high stores `cfg_wdata[7:0]` as the boundary of row k when `cfg_addr` is k (0 to 7). Address 8 loads the width bits. Address 9 loads the mode fields. Writes to any other address change nothing.
- R3: `row_pop[i]` is 1 exactly when row i's boundary differs from row i-1's boundary, where the boundary below row 0 is 0.
- R4: A populated row i matches pages from (boundary of row i-1) << s up to (boundary of row i) << s minus 1. Here s is 13 for a 32 MiB unit and 14 for a 64 MiB unit.
- R5: The boundary unit is 32 MiB when mode bits 19:18 are 00 and 64 MiB otherwise. When `fixed_dual` is 1 the unit is always 64 MiB.
- R6: The channel mode is dual when mode bit 22 is 1, or when `fixed_dual` is 1. Otherwise it is single.
- R7: `row_x4[i]` equals bit 4*i+3 of the last word written to address 8, where 1 means x4 devices and 0 means x8.
- R8: `row_ecc[2*i+1:2*i]` is coded as follows: 0 = none, 1 = SECDED, 2 = S4EC/D4ED. The code is 0 when mode bits 21:20 are 00 or the row is unpopulated. It is 2 for a populated x4 row in dual-channel mode, and 1 for every other populated row.
- R9: A page that no populated row matches gives `rsp_miss` = 1 with `rsp_row` = 0. An unpopulated row never matches. When several rows could match, the lowest index wins.
- R10: A request accepted at a clock edge gives `rsp_valid` high right after that edge. Its row and miss flag are computed from the configuration in place at that edge, and responses come out in request order.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response stays unchanged and `req_ready` is low. Otherwise `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (4) | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| fixed_dual | input | 1 | Strap: variant always dual-channel, 64 MiB unit |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_page | input | PAGE_W (22) | Page number to decode |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_row | output | ROW_W (3) | Matching row index, 0 on miss |
| rsp_miss | output | 1 | No populated row contains the page |
| row_pop | output | NUM_ROWS (8) | Row populated flags |
| row_x4 | output | NUM_ROWS (8) | Row uses x4 devices |
| row_ecc | output | 2*NUM_ROWS (16) | Per-row ECC scheme code |

## Verification
The hardest case to reach from the ports is a lookup that lands right on a shared edge. This happens when a page sits exactly at the top boundary of a row and an empty row lies between two populated ones. It must also happen while the response port is stalled and the boundary unit or the strap differs from the one used a moment before. The stimulus builds a layout with empty rows between populated ones. It then probes the first and last page of each populated range and the first page past the total. The same pages are replayed after switching the unit field, the strap and the ECC fields. A final burst runs under a pseudo-random `rsp_ready` pattern, so that responses pile up against back-pressure while the scoreboard checks their order.

// File: rtl/rowmap_pkg.sv
package rowmap_pkg;
  localparam int CFG_W         = 32;
  localparam int MODE_GRAN_LSB = 18;
  localparam int MODE_ECC_LSB  = 20;
  localparam int MODE_DUAL_BIT = 22;
  localparam int ATTR_STRIDE   = 4;
  localparam int ATTR_WIDTH_OFS = 3;

  typedef enum logic [1:0] {
    ECC_OFF    = 2'd0,
    ECC_SECDED = 2'd1,
    ECC_S4EC   = 2'd2
  } ecc_mode_e;
endpackage

// File: rtl/rowmap_cfg_regs.sv
module rowmap_cfg_regs
  import rowmap_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int BND_W    = 8,
  parameter int ADDR_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [ADDR_W-1:0]              cfg_addr,
  input  logic [CFG_W-1:0]               cfg_wdata,
  output logic [NUM_ROWS-1:0][BND_W-1:0] bnd,
  output logic [NUM_ROWS-1:0]            width_x4,
  output logic [1:0]                     gran_fld,
  output logic [1:0]                     ecc_fld,
  output logic                           dual_bit
);
  localparam int WIDTH_ADDR = NUM_ROWS;
  localparam int MODE_ADDR  = NUM_ROWS + 1;

  logic [CFG_W-1:0] unused_wdata_bits;
  assign unused_wdata_bits = cfg_wdata;

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_bnd
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bnd[i]      <= '0;
        width_x4[i] <= 1'b0;
      end else if (cfg_we) begin
        if (cfg_addr == ADDR_W'(i))
          bnd[i] <= cfg_wdata[BND_W-1:0];
        if (cfg_addr == ADDR_W'(WIDTH_ADDR))
          width_x4[i] <= cfg_wdata[ATTR_STRIDE*i+ATTR_WIDTH_OFS];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gran_fld <= '0;
      ecc_fld  <= '0;
      dual_bit <= 1'b0;
    end else if (cfg_we && cfg_addr == ADDR_W'(MODE_ADDR)) begin
      gran_fld <= cfg_wdata[MODE_GRAN_LSB+:2];
      ecc_fld  <= cfg_wdata[MODE_ECC_LSB+:2];
      dual_bit <= cfg_wdata[MODE_DUAL_BIT];
    end
  end
endmodule

// File: rtl/rowmap_row_class.sv
module rowmap_row_class
  import rowmap_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int BND_W    = 8
) (
  input  logic [NUM_ROWS-1:0][BND_W-1:0] bnd,
  input  logic [NUM_ROWS-1:0]            width_x4,
  input  logic [1:0]                     gran_fld,
  input  logic [1:0]                     ecc_fld,
  input  logic                           dual_bit,
  input  logic                           fixed_dual,
  output logic [NUM_ROWS-1:0]            row_pop,
  output logic [2*NUM_ROWS-1:0]          row_ecc,
  output logic                           gran64
);
  logic dual_ch;
  logic ecc_on;

  assign dual_ch = fixed_dual | dual_bit;
  assign gran64  = fixed_dual | (gran_fld != 2'b00);
  assign ecc_on  = (ecc_fld != 2'b00);

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    logic [BND_W-1:0] below;
    ecc_mode_e        scheme;
    if (i == 0) begin : g_first
      assign below = '0;
    end else begin : g_next
      assign below = bnd[i-1];
    end
    assign row_pop[i] = (bnd[i] != below);
    always_comb begin
      if (!ecc_on || !row_pop[i])       scheme = ECC_OFF;
      else if (dual_ch && width_x4[i])  scheme = ECC_S4EC;
      else                              scheme = ECC_SECDED;
    end
    assign row_ecc[2*i+:2] = scheme;
  end
endmodule

// File: rtl/rowmap_lookup.sv
module rowmap_lookup #(
  parameter int NUM_ROWS = 8,
  parameter int BND_W    = 8,
  parameter int PAGE_W   = 22,
  parameter int SHIFT_LO = 13,
  parameter int ROW_W    = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_ROWS-1:0][BND_W-1:0] bnd,
  input  logic [NUM_ROWS-1:0]            row_pop,
  input  logic                           gran64,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [PAGE_W-1:0]              req_page,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic [ROW_W-1:0]               rsp_row,
  output logic                           rsp_miss
);
  logic [NUM_ROWS-1:0] hit;
  logic [ROW_W-1:0]    sel_row;
  logic                found;
  logic                accept;

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_cmp
    logic [PAGE_W-1:0] top_pg;
    logic [PAGE_W-1:0] base_pg;
    assign top_pg = gran64 ? (PAGE_W'(bnd[i]) << (SHIFT_LO + 1))
                           : (PAGE_W'(bnd[i]) << SHIFT_LO);
    if (i == 0) begin : g_first
      assign base_pg = '0;
    end else begin : g_next
      assign base_pg = gran64 ? (PAGE_W'(bnd[i-1]) << (SHIFT_LO + 1))
                              : (PAGE_W'(bnd[i-1]) << SHIFT_LO);
    end
    assign hit[i] = row_pop[i] && (req_page >= base_pg) && (req_page < top_pg);
  end

  always_comb begin
    sel_row = '0;
    found   = 1'b0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_row = ROW_W'(i);
        found   = 1'b1;
      end
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_row   <= '0;
      rsp_miss  <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_row   <= found ? sel_row : '0;
      rsp_miss  <= !found;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/row_map_decoder.sv
module row_map_decoder
  import rowmap_pkg::*;
#(
  parameter int  NUM_ROWS   = 8,
  parameter int  BND_W      = 8,
  parameter int  PAGE_SHIFT = 12,
  localparam int SHIFT_LO   = 25 - PAGE_SHIFT,
  localparam int PAGE_W     = BND_W + SHIFT_LO + 1,
  localparam int ROW_W      = $clog2(NUM_ROWS),
  localparam int ADDR_W     = $clog2(NUM_ROWS + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [31:0]           cfg_wdata,
  input  logic                  fixed_dual,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [PAGE_W-1:0]     req_page,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [ROW_W-1:0]      rsp_row,
  output logic                  rsp_miss,
  output logic [NUM_ROWS-1:0]   row_pop,
  output logic [NUM_ROWS-1:0]   row_x4,
  output logic [2*NUM_ROWS-1:0] row_ecc
);
  logic [NUM_ROWS-1:0][BND_W-1:0] bnd;
  logic [1:0] gran_fld;
  logic [1:0] ecc_fld;
  logic       dual_bit;
  logic       gran64;

  rowmap_cfg_regs #(
    .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bnd(bnd), .width_x4(row_x4),
    .gran_fld(gran_fld), .ecc_fld(ecc_fld), .dual_bit(dual_bit)
  );

  rowmap_row_class #(
    .NUM_ROWS(NUM_ROWS), .BND_W(BND_W)
  ) u_class (
    .bnd(bnd), .width_x4(row_x4), .gran_fld(gran_fld), .ecc_fld(ecc_fld),
    .dual_bit(dual_bit), .fixed_dual(fixed_dual), .row_pop(row_pop),
    .row_ecc(row_ecc), .gran64(gran64)
  );

  rowmap_lookup #(
    .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .PAGE_W(PAGE_W),
    .SHIFT_LO(SHIFT_LO), .ROW_W(ROW_W)
  ) u_look (
    .clk(clk), .rst_n(rst_n), .bnd(bnd), .row_pop(row_pop), .gran64(gran64),
    .req_valid(req_valid), .req_ready(req_ready), .req_page(req_page),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_row(rsp_row),
    .rsp_miss(rsp_miss)
  );
endmodule

// File: rtl/row_map_decoder_chk.sv
module row_map_decoder_chk #(
  parameter int NUM_ROWS = 8,
  parameter int ROW_W    = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [ROW_W-1:0]      rsp_row,
  input logic                  rsp_miss,
  input logic [NUM_ROWS-1:0]   row_pop,
  input logic [2*NUM_ROWS-1:0] row_ecc
);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_row) && $stable(rsp_miss));

  a_r11_block: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  a_r10_origin: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready) || $past(rsp_valid && !rsp_ready));

  a_r9_miss_row0: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_miss |-> rsp_row == '0);

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_ecc
    a_r8_empty_none: assert property (@(posedge clk) disable iff (!rst_n)
      !row_pop[i] |-> row_ecc[2*i+:2] == 2'd0);
    a_r8_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      row_ecc[2*i+:2] != 2'd3);
  end
endmodule

bind row_map_decoder row_map_decoder_chk #(
  .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_row(rsp_row),
  .rsp_miss(rsp_miss), .row_pop(row_pop), .row_ecc(row_ecc)
);

// File: tb/row_map_decoder_bench.sv
module row_map_decoder_bench;
  localparam int NR = 8;
  localparam int PW = 22;
  localparam int RW = 3;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          fixed_dual = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [PW-1:0] req_page = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [RW-1:0] rsp_row;
  logic          rsp_miss;
  logic [NR-1:0] row_pop, row_x4;
  logic [2*NR-1:0] row_ecc;

  row_map_decoder u_row_map_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fixed_dual(fixed_dual), .req_valid(req_valid),
    .req_ready(req_ready), .req_page(req_page), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_row(rsp_row), .rsp_miss(rsp_miss),
    .row_pop(row_pop), .row_x4(row_x4), .row_ecc(row_ecc)
  );

  int n_chk = 0;
  int n_bad = 0;
  int bnd_m [NR];
  logic [31:0] mode_m = '0;

  logic [3:0] exp_q [$];
  int         pg_q  [$];
  string      tag_q [$];
  logic [3:0] e_m;
  int         p_m;
  string      t_m;

  logic [7:0] lfsr = 8'h5A;
  logic       stall_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [3:0] model(input int page);
    int s;
    int lo;
    logic [3:0] res;
    s = (fixed_dual || mode_m[19:18] != 2'b00) ? 14 : 13;
    res = 4'b1000;
    for (int i = NR - 1; i >= 0; i--) begin
      lo = (i == 0) ? 0 : bnd_m[i-1];
      if (bnd_m[i] != lo && page >= (lo << s) && page < (bnd_m[i] << s))
        res = {1'b0, 3'(i)};
    end
    return res;
  endfunction

  task automatic wr(input int addr, input logic [31:0] data);
    cfg_we = 1'b1;
    cfg_addr = AW'(addr);
    cfg_wdata = data;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    if (addr < NR) bnd_m[addr] = int'(data[7:0]);
    if (addr == NR + 1) mode_m = data;
  endtask

  task automatic send(input int page, input string tag);
    req_valid = 1'b1;
    req_page = PW'(page);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    exp_q.push_back(model(page));
    pg_q.push_back(page);
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (stall_en) rsp_ready = lfsr[0];
  end

  always @(negedge clk) begin
    if (rst_n && rsp_valid && !rsp_ready)
      chk(req_ready == 1'b0, "R11 req_ready while stalled", 32'(req_ready), 32'd0);
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 response with no request", {28'd0, rsp_miss, rsp_row}, 32'hFFFF);
      end else begin
        e_m = exp_q.pop_front();
        p_m = pg_q.pop_front();
        t_m = tag_q.pop_front();
        n_chk++;
        if ({rsp_miss, rsp_row} !== e_m) begin
          n_bad++;
          $display("FAIL %s page=%0d actual miss=%0d row=%0d expected miss=%0d row=%0d",
                   t_m, p_m, rsp_miss, rsp_row, e_m[3], e_m[2:0]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) bnd_m[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(row_pop == '0, "R1 row_pop reset", 32'(row_pop), 32'd0);
    chk(row_ecc == '0, "R1 row_ecc reset", 32'(row_ecc), 32'd0);
    chk(row_x4 == '0, "R1 row_x4 reset", 32'(row_x4), 32'd0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(req_ready == 1'b1, "R1 req_ready idle", 32'(req_ready), 32'd1);
    send(0, "R9 empty layout miss");
    send(1000, "R9 empty layout miss");
    drain();

    // layout with empty rows 1,3,4,6; x4 on rows 2,3,5; 32 MiB unit, dual, ECC on
    wr(0, 32'd2); wr(1, 32'd2); wr(2, 32'd5); wr(3, 32'd5);
    wr(4, 32'd5); wr(5, 32'd9); wr(6, 32'd9); wr(7, 32'hABCD_FF0C);
    wr(8, 32'h0080_8800);
    wr(9, 32'h0050_0000);
    chk(row_pop == 8'hA5, "R3 populated rows", 32'(row_pop), 32'hA5);
    chk(row_x4 == 8'h2C, "R7 width bits", 32'(row_x4), 32'h2C);
    chk(row_ecc == 16'h4821, "R8 dual x4 ecc", 32'(row_ecc), 32'h4821);
    send(0, "R4 first page row0");
    send(16383, "R4 last page row0");
    send(16384, "R4 first page row2 skips empty row1");
    send(40959, "R4 last page row2");
    send(40960, "R4 first page row5");
    send(98303, "R4 last page row7 (R2 low byte)");
    send(98304, "R9 just past total");
    send(22'h3FFFFF, "R9 top page");
    drain();

    wr(10, 32'hFFFF_FFFF);
    wr(15, 32'hFFFF_FFFF);
    chk(row_pop == 8'hA5, "R2 bad address ignored pop", 32'(row_pop), 32'hA5);
    chk(row_ecc == 16'h4821, "R2 bad address ignored ecc", 32'(row_ecc), 32'h4821);
    send(16384, "R2 bad address ignored lookup");
    drain();

    wr(9, 32'h0010_0000);
    chk(row_ecc == 16'h4411, "R6 single channel secded", 32'(row_ecc), 32'h4411);
    fixed_dual = 1'b1;
    #1;
    chk(row_ecc == 16'h4821, "R6 strap forces dual", 32'(row_ecc), 32'h4821);
    @(posedge clk);
    #1;
    send(16384, "R5 strap forces 64MiB");
    send(32768, "R5 strap forces 64MiB row2");
    drain();
    fixed_dual = 1'b0;
    @(posedge clk);
    #1;
    send(16384, "R5 strap released 32MiB");
    drain();

    wr(9, 32'h0040_0000);
    chk(row_ecc == 16'h0000, "R8 ecc field zero", 32'(row_ecc), 32'h0);
    wr(9, 32'h0060_0000);
    chk(row_ecc == 16'h4821, "R8 ecc field 2 enables", 32'(row_ecc), 32'h4821);

    wr(9, 32'h0058_0000);
    send(16384, "R5 64MiB unit row0");
    send(32767, "R5 64MiB last page row0");
    send(32768, "R5 64MiB row2");
    send(196607, "R5 64MiB last page row7");
    send(196608, "R9 64MiB past total");
    drain();

    wr(9, 32'h0050_0000);
    stall_en = 1'b1;
    for (int k = 0; k < 40; k++)
      send((k * 2731) % 110000, "R11 stalled burst order");
    drain();
    stall_en = 1'b0;
    rsp_ready = 1'b1;
    wr(1, 32'd1);
    chk(row_pop == 8'hA7, "R3 row1 filled", 32'(row_pop), 32'hA7);
    send(8192, "R10 new layout used at accept");
    send(8191, "R10 new layout row0");
    drain();

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule